// File: doc/BRIEF.md
# Interrupt Affinity Routing Register Bank

This block keeps one routing entry for every shared interrupt in an extended interrupt range. Each entry names either one processing element, by a four-level affinity address, or a "participating element" mode. Software reaches the entries through a simple memory-mapped port with 32-bit reads and writes. The same port filters each access by the extended-range enable, the implemented range size and the security state of the access.

A second port asks for a routing decision. The caller presents an interrupt index together with the affinity, implemented and participating vectors of the processing elements. One cycle later the block returns a valid pulse and a target index, or a flag saying that no target exists. When the flag is set, the interrupt stays pending.

Top module: `irq_route_bank`

## Requirements
- R1: Entry layout. The low word holds affinity level 0 in bits [7:0], level 1 in [15:8], level 2 in [23:16] and the mode bit in bit 31. The high word holds affinity level 3 in bits [7:0]. All other bits read as zero, and writes to them are ignored.
- R2: Entry m sits at byte offset 8*m. `bus_addr` carries the byte offset bits [ADDR_W-1:2], so `bus_addr[2]`=0 selects the low word and `bus_addr[2]`=1 selects the high word.
- R3: Byte enable k (`bus_be[k]`) controls byte lane k of the addressed word. A lane whose enable is clear keeps its value.
- R4: When `cfg_ext_en`=0, every read returns zero and every write is ignored.
- R5: Only indexes from 0 to (`cfg_range`+1)*32-1 are implemented. An access above that index reads as zero and its write is ignored.
- R6: An access is refused when `cfg_sec_dis`=0, `bus_ns`=1 and `irq_secure[m]`=1. A refused access reads as zero and its write is ignored. A secure access, or any access made while `cfg_sec_dis`=1, is accepted.
- R7: A read accepted at a clock edge raises `bus_rvalid` for one cycle after that edge, and `bus_rdata` is valid in that same cycle.
- R8: After reset every entry is zero, and `rt_valid` and `bus_rvalid` are low.
- R9: With mode 0, the target is the implemented element whose affinity `pe_aff[32k+31:32k]` equals {level3, level2, level1, level0}, with level 3 in the top byte. If several elements match, the lowest index wins.
- R10: With mode 0 and no implemented element matching, `rt_none`=1 and `rt_target`=0.
- R11: With mode 1, the target is the lowest-numbered element with `pe_part[k]`=1 and the affinity fields are ignored. If no element participates, `rt_none`=1 and `rt_target`=0.
- R12: A routing request for an index that is not implemented, or any request while `cfg_ext_en`=0, gives `rt_none`=1. Security settings do not affect routing.
- R13: `rt_valid` is high exactly in the cycle after a cycle with `rt_req`=1. A routing request uses the entry contents from before any write that is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ext_en | input | 1 | Extended range enabled |
| cfg_range | input | RANGE_W | Implemented range size; count = (value+1)*32 |
| cfg_sec_dis | input | 1 | Security filtering disabled when 1 |
| irq_secure | input | NUM_ENT | Per interrupt: 1 for Group 0 or Secure Group 1 |
| bus_req | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W-2 | Byte offset bits [ADDR_W-1:2] |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_ns | input | 1 | Access is non-secure |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| rt_req | input | 1 | Routing request |
| rt_idx | input | IDX_W | Interrupt index to route |
| pe_aff | input | 32*NUM_PE | Affinity of each element |
| pe_impl | input | NUM_PE | Element implemented |
| pe_part | input | NUM_PE | Element participates in mode 1 |
| rt_valid | output | 1 | Routing result valid |
| rt_target | output | PE_W | Chosen element |
| rt_none | output | 1 | No target; interrupt stays pending |

## Verification
A register write and a routing decision for the same entry can be accepted in the same cycle. The bench provokes this by driving a write and a routing request for the same entry on one clock edge. The write switches the entry from a mode-0 target to mode 1 while a different element participates. The first result must still name the old mode-0 target. A second request made afterwards must name the participating element, which proves that the write took effect.

// File: rtl/irq_route_pkg.sv
// Shared types for the interrupt affinity routing bank.
// Assumes: affinity levels are 8 bits wide and pe_aff packs them level3..level0.
package irq_route_pkg;

    typedef struct packed {
        logic       mode;   // 1: any participating element
        logic [7:0] a3;
        logic [7:0] a2;
        logic [7:0] a1;
        logic [7:0] a0;
    } route_ent_t;

    localparam int ENT_LANES = 4;

endpackage

// File: rtl/irq_route_access.sv
// Access qualifier: decides if an index is implemented and if an access may see it.
// Assumes IDX_W = RANGE_W + 5, so every range value maps to a whole number of entries.
module irq_route_access #(
    parameter int IDX_W   = 6,
    parameter int RANGE_W = 1
) (
    input  logic               ext_en,
    input  logic [RANGE_W-1:0] range_sel,
    input  logic               sec_dis,
    input  logic               ns_acc,
    input  logic               secure_irq,
    input  logic [IDX_W-1:0]   idx,
    output logic               allowed
);
    localparam int LIM_W = IDX_W + 1;

    logic [LIM_W-1:0] count;
    logic             in_range;
    logic             blocked;

    // Number of implemented entries and the security filter.
    always_comb begin
        count    = (LIM_W'(range_sel) + LIM_W'(1)) << 5;
        in_range = ext_en && (LIM_W'(idx) < count);
        blocked  = ns_acc && !sec_dis && secure_irq;
        allowed  = in_range && !blocked;
    end

endmodule

// File: rtl/irq_route_regs.sv
// Entry storage with a 32-bit word port and a combinational route lookup port.
// Assumes wr_en is already qualified; rd_ok says if a read may return data.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int NUM_ENT = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             rd_ok,
    input  logic             word_hi,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    input  logic [3:0]       be,
    output logic             rvalid,
    output logic [31:0]      rdata,
    input  logic [IDX_W-1:0] lk_idx,
    output route_ent_t       lk_ent
);
    route_ent_t  store [NUM_ENT];
    route_ent_t  cur;
    logic [31:0] cur_word;
    logic        hi_q;

    // Addressed entry, its word view, and the lookup entry.
    always_comb begin
        cur      = store[idx];
        cur_word = word_hi ? {24'd0, cur.a3} : {cur.mode, 7'd0, cur.a2, cur.a1, cur.a0};
        lk_ent   = store[lk_idx];
    end

    // Entry update per byte lane; reserved bits have no storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) store[i] <= '0;
        end else if (wr_en) begin
            if (word_hi) begin
                if (be[0]) store[idx].a3 <= wdata[7:0];
            end else begin
                if (be[0]) store[idx].a0   <= wdata[7:0];
                if (be[1]) store[idx].a1   <= wdata[15:8];
                if (be[2]) store[idx].a2   <= wdata[23:16];
                if (be[3]) store[idx].mode <= wdata[31];
            end
        end
    end

    // Registered read return; refused reads give zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
            hi_q   <= 1'b0;
        end else begin
            rvalid <= rd_en;
            hi_q   <= word_hi;
            rdata  <= (rd_en && rd_ok) ? cur_word : '0;
        end
    end

    p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    p_rsvd_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && hi_q) |-> (rdata[31:8] == 24'd0));
    p_rsvd_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !hi_q) |-> (rdata[30:24] == 7'd0));
    p_refused_raz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_ok) |=> (rdata == 32'd0));

endmodule

// File: rtl/irq_route_select.sv
// Target selection: builds a candidate per element and picks the lowest index.
// Assumes NUM_PE >= 2 and that pe_aff packs element k at bits [32k+31:32k].
module irq_route_select
    import irq_route_pkg::*;
#(
    parameter int NUM_PE = 8,
    localparam int PE_W = $clog2(NUM_PE)
) (
    input  route_ent_t          ent,
    input  logic [32*NUM_PE-1:0] pe_aff,
    input  logic [NUM_PE-1:0]   pe_impl,
    input  logic [NUM_PE-1:0]   pe_part,
    output logic                found,
    output logic [PE_W-1:0]     pick
);
    logic [NUM_PE-1:0] cand;
    logic [31:0]       want;

    assign want = {ent.a3, ent.a2, ent.a1, ent.a0};

    for (genvar k = 0; k < NUM_PE; k++) begin : g_cand
        assign cand[k] = ent.mode ? pe_part[k]
                                  : (pe_impl[k] && (pe_aff[32*k +: 32] == want));
    end

    // Fixed priority: the lowest set candidate wins.
    always_comb begin
        found = |cand;
        pick  = '0;
        for (int k = NUM_PE - 1; k >= 0; k--) begin
            if (cand[k]) pick = PE_W'(k);
        end
    end

endmodule

// File: rtl/irq_route_bank.sv
// Interrupt affinity routing bank: register port plus a registered routing decision.
// Assumes word-aligned accesses; byte offset bits [1:0] are not carried.
module irq_route_bank
    import irq_route_pkg::*;
#(
    parameter int RANGE_W = 1,
    parameter int NUM_PE  = 8,
    localparam int IDX_W   = RANGE_W + 5,
    localparam int NUM_ENT = 1 << IDX_W,
    localparam int ADDR_W  = IDX_W + 3,
    localparam int PE_W    = $clog2(NUM_PE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_ext_en,
    input  logic [RANGE_W-1:0]   cfg_range,
    input  logic                 cfg_sec_dis,
    input  logic [NUM_ENT-1:0]   irq_secure,
    input  logic                 bus_req,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:2]    bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [3:0]           bus_be,
    input  logic                 bus_ns,
    output logic                 bus_rvalid,
    output logic [31:0]          bus_rdata,
    input  logic                 rt_req,
    input  logic [IDX_W-1:0]     rt_idx,
    input  logic [32*NUM_PE-1:0] pe_aff,
    input  logic [NUM_PE-1:0]    pe_impl,
    input  logic [NUM_PE-1:0]    pe_part,
    output logic                 rt_valid,
    output logic [PE_W-1:0]      rt_target,
    output logic                 rt_none
);
    logic [IDX_W-1:0] bus_idx;
    logic             bus_hi;
    logic             bus_ok;
    logic             rt_ok;
    route_ent_t       rt_ent;
    logic             sel_found;
    logic [PE_W-1:0]  sel_pick;

    assign bus_idx = bus_addr[ADDR_W-1:3];
    assign bus_hi  = bus_addr[2];

    irq_route_access #(.IDX_W(IDX_W), .RANGE_W(RANGE_W)) u_bus_acc (
        .ext_en     (cfg_ext_en),
        .range_sel  (cfg_range),
        .sec_dis    (cfg_sec_dis),
        .ns_acc     (bus_ns),
        .secure_irq (irq_secure[bus_idx]),
        .idx        (bus_idx),
        .allowed    (bus_ok)
    );

    // Routing ignores security, so only the range check remains.
    irq_route_access #(.IDX_W(IDX_W), .RANGE_W(RANGE_W)) u_rt_acc (
        .ext_en     (cfg_ext_en),
        .range_sel  (cfg_range),
        .sec_dis    (1'b1),
        .ns_acc     (1'b0),
        .secure_irq (1'b0),
        .idx        (rt_idx),
        .allowed    (rt_ok)
    );

    irq_route_regs #(.IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_req && bus_wr && bus_ok),
        .rd_en   (bus_req && !bus_wr),
        .rd_ok   (bus_ok),
        .word_hi (bus_hi),
        .idx     (bus_idx),
        .wdata   (bus_wdata),
        .be      (bus_be),
        .rvalid  (bus_rvalid),
        .rdata   (bus_rdata),
        .lk_idx  (rt_idx),
        .lk_ent  (rt_ent)
    );

    irq_route_select #(.NUM_PE(NUM_PE)) u_sel (
        .ent     (rt_ent),
        .pe_aff  (pe_aff),
        .pe_impl (pe_impl),
        .pe_part (pe_part),
        .found   (sel_found),
        .pick    (sel_pick)
    );

    // Registered routing result, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_valid  <= 1'b0;
            rt_none   <= 1'b0;
            rt_target <= '0;
        end else begin
            rt_valid <= rt_req;
            if (rt_req) begin
                rt_none   <= !(rt_ok && sel_found);
                rt_target <= (rt_ok && sel_found) ? sel_pick : '0;
            end
        end
    end

    p_valid_follows_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rt_req |=> rt_valid);
    p_valid_only_after_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_req |=> !rt_valid);
    p_none_target_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_none) |-> (rt_target == '0));
    p_disabled_no_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_req && !cfg_ext_en) |=> rt_none);
    p_mode1_participant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_req && rt_ok && rt_ent.mode) |=> (rt_none || (((pe_part_q >> rt_target) & 1'b1) != 0)));

    logic [NUM_PE-1:0] pe_part_q;
    always_ff @(posedge clk) begin
        if (!rst_n) pe_part_q <= '0;
        else        pe_part_q <= pe_part;
    end

endmodule

// File: tb/irq_route_bank_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of register accesses, then directed tests.
module irq_route_bank_tb_top;
    localparam int RANGE_W = 1;
    localparam int NUM_PE  = 8;
    localparam int IDX_W   = RANGE_W + 5;
    localparam int NUM_ENT = 1 << IDX_W;
    localparam int ADDR_W  = IDX_W + 3;
    localparam int PE_W    = $clog2(NUM_PE);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cfg_ext_en = 1'b1;
    logic [RANGE_W-1:0]   cfg_range = 1'b1;
    logic                 cfg_sec_dis = 1'b0;
    logic [NUM_ENT-1:0]   irq_secure = '0;
    logic                 bus_req = 1'b0;
    logic                 bus_wr = 1'b0;
    logic [ADDR_W-1:2]    bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [3:0]           bus_be = '0;
    logic                 bus_ns = 1'b0;
    logic                 bus_rvalid;
    logic [31:0]          bus_rdata;
    logic                 rt_req = 1'b0;
    logic [IDX_W-1:0]     rt_idx = '0;
    logic [32*NUM_PE-1:0] pe_aff = '0;
    logic [NUM_PE-1:0]    pe_impl = 8'b0111_1111;
    logic [NUM_PE-1:0]    pe_part = '0;
    logic                 rt_valid;
    logic [PE_W-1:0]      rt_target;
    logic                 rt_none;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    irq_route_bank #(.RANGE_W(RANGE_W), .NUM_PE(NUM_PE)) dut_i (.*);

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic        ns;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h010, 32'hFFFF_FFFF, 4'hF, 1'b0, 32'h0, 4'd1},
        '{1'b0, 12'h010, 32'h0, 4'h0, 1'b0, 32'h80FF_FFFF, 4'd1}, // R1 low reserved
        '{1'b1, 12'h014, 32'hFFFF_FFFF, 4'hF, 1'b0, 32'h0, 4'd1},
        '{1'b0, 12'h014, 32'h0, 4'h0, 1'b0, 32'h0000_00FF, 4'd1}, // R1 high reserved
        '{1'b1, 12'h010, 32'h0000_0012, 4'h1, 1'b0, 32'h0, 4'd3},
        '{1'b0, 12'h010, 32'h0, 4'h0, 1'b0, 32'h80FF_FF12, 4'd3}, // R3 lane 0
        '{1'b1, 12'h010, 32'h0000_3400, 4'hA, 1'b0, 32'h0, 4'd3},
        '{1'b0, 12'h010, 32'h0, 4'h0, 1'b0, 32'h00FF_3412, 4'd3}, // R3 lanes 1,3
        '{1'b1, 12'h018, 32'h0000_00AB, 4'hF, 1'b1, 32'h0, 4'd6},
        '{1'b0, 12'h018, 32'h0, 4'h0, 1'b0, 32'h0, 4'd6},         // R6 ns write ignored
        '{1'b1, 12'h018, 32'h0000_00AB, 4'hF, 1'b0, 32'h0, 4'd6},
        '{1'b0, 12'h018, 32'h0, 4'h0, 1'b1, 32'h0, 4'd6},         // R6 ns read RAZ
        '{1'b0, 12'h018, 32'h0, 4'h0, 1'b0, 32'h0000_00AB, 4'd6}, // R6 secure read
        '{1'b1, 12'h1F8, 32'h0000_0055, 4'hF, 1'b0, 32'h0, 4'd2},
        '{1'b0, 12'h1F8, 32'h0, 4'h0, 1'b0, 32'h0000_0055, 4'd2}, // R2 top entry
        '{1'b0, 12'h1FC, 32'h0, 4'h0, 1'b0, 32'h0, 4'd2},         // R2 high word
        '{1'b0, 12'h014, 32'h0, 4'h0, 1'b0, 32'h0000_00FF, 4'd2}  // R2 entry 2 high
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b, input logic ns);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a[ADDR_W-1:2];
        bus_wdata = d; bus_be = b; bus_ns = ns;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic ns, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a[ADDR_W-1:2]; bus_ns = ns;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
    endtask

    task automatic route(input int id, output logic [31:0] res);
        @(negedge clk);
        rt_req = 1'b1; rt_idx = IDX_W'(id);
        @(negedge clk);
        rt_req = 1'b0;
        res = {rt_valid, 15'd0, 7'd0, rt_none, 5'd0, 3'(rt_target)};
    endtask

    // Packs an expected routing result: valid, none flag, target.
    function automatic logic [31:0] rexp(input logic none, input int t);
        return {1'b1, 15'd0, 7'd0, none, 5'd0, 3'(t)};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int k = 0; k < NUM_PE; k++)
            pe_aff[32*k +: 32] = {8'(16 + k), 8'h02, 8'h01, 8'(k)};
        irq_secure[3] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        chk("R8 rvalid", 32'(bus_rvalid), 32'd0);
        chk("R8 rt_valid", 32'(rt_valid), 32'd0);
        bus_read(12'h000, 1'b0, r);
        chk("R8 entry0 low", r, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].data, VEC[i].be, VEC[i].ns);
            else begin
                bus_read(VEC[i].addr, VEC[i].ns, r);
                chk($sformatf("R%0d vec %0d", VEC[i].req, i), r, VEC[i].exp);
            end
        end

        // R6: security disabled lets ns accesses through
        cfg_sec_dis = 1'b1;
        bus_read(12'h018, 1'b1, r);
        chk("R6 sec_dis ns read", r, 32'h0000_00AB);
        cfg_sec_dis = 1'b0;

        // R7: rvalid drops after the read cycle
        @(negedge clk);
        chk("R7 rvalid one cycle", 32'(bus_rvalid), 32'd0);

        // R4: extended range disabled
        cfg_ext_en = 1'b0;
        bus_write(12'h010, 32'h0, 4'hF, 1'b0);
        bus_read(12'h010, 1'b0, r);
        chk("R4 disabled read", r, 32'd0);
        cfg_ext_en = 1'b1;
        bus_read(12'h010, 1'b0, r);
        chk("R4 write ignored", r, 32'h00FF_3412);

        // R5: range limit
        cfg_range = 1'b0;
        bus_write(12'h140, 32'h0000_0077, 4'hF, 1'b0);
        cfg_range = 1'b1;
        bus_read(12'h140, 1'b0, r);
        chk("R5 write above limit ignored", r, 32'd0);
        bus_write(12'h140, 32'h0000_0077, 4'hF, 1'b0);
        cfg_range = 1'b0;
        bus_read(12'h140, 1'b0, r);
        chk("R5 read above limit RAZ", r, 32'd0);
        bus_read(12'h0F8, 1'b0, r);
        chk("R5 entry31 inside limit", r, 32'd0);

        // Routing entries: 10 -> PE3, 11 -> PE7 (unimplemented), 12 mode 1
        bus_write(12'h050, 32'h0002_0103, 4'hF, 1'b0);
        bus_write(12'h054, 32'h0000_0013, 4'hF, 1'b0);
        bus_write(12'h058, 32'h0002_0107, 4'hF, 1'b0);
        bus_write(12'h05C, 32'h0000_0017, 4'hF, 1'b0);
        bus_write(12'h060, 32'h8000_0000, 4'hF, 1'b0);
        bus_write(12'h064, 32'h0000_0013, 4'hF, 1'b0);

        route(10, r); chk("R9 mode0 match PE3", r, rexp(1'b0, 3));
        route(11, r); chk("R10 unimplemented PE", r, rexp(1'b1, 0));
        route(13, r); chk("R10 no affinity match", r, rexp(1'b1, 0));
        pe_part = 8'b0011_0100;
        route(12, r); chk("R11 lowest participant", r, rexp(1'b0, 2));
        pe_part = 8'b1000_0000;
        route(12, r); chk("R11 top participant", r, rexp(1'b0, 7));
        pe_part = '0;
        route(12, r); chk("R11 none participate", r, rexp(1'b1, 0));

        // R12: out of range, disabled, security not applied
        cfg_range = 1'b0;
        route(40, r); chk("R12 above limit", r, rexp(1'b1, 0));
        cfg_range = 1'b1;
        cfg_ext_en = 1'b0;
        route(10, r); chk("R12 ext disabled", r, rexp(1'b1, 0));
        cfg_ext_en = 1'b1;
        irq_secure[10] = 1'b1;
        route(10, r); chk("R12 secure irq still routed", r, rexp(1'b0, 3));

        // R13: same-cycle write and route on entry 10
        pe_part = 8'b0100_0000;
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 10'h050 >> 2;
        bus_wdata = 32'h8000_0000; bus_be = 4'h8; bus_ns = 1'b0;
        rt_req = 1'b1; rt_idx = IDX_W'(10);
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0; rt_req = 1'b0;
        chk("R13 old entry used", {rt_valid, 15'd0, 7'd0, rt_none, 5'd0, 3'(rt_target)}, rexp(1'b0, 3));
        @(negedge clk);
        chk("R13 valid single cycle", 32'(rt_valid), 32'd0);
        route(10, r); chk("R13 new entry used", r, rexp(1'b0, 6));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule